// File: doc/BRIEF.md
# Three-Phase Carrier PWM Gate Generator

This block drives the six switches of a three-phase, two-level bridge. A shared up/down counter forms a triangular carrier. Each phase compares its own signed reference against that carrier to get a switching command. A per-leg dead-band stage then turns the command into a complementary upper/lower gate pair. When the command changes, the gate that must turn off drops at once. The gate that must turn on waits a programmable number of clock cycles.

The carrier half period and the dead time come from two configuration inputs. With a 100 MHz clock, a half period of 2500 gives a 20 kHz carrier and a dead count of 250 gives 2.5 µs.

References are plain levels, not a stream. The block samples them only at the two carrier extremes, so a reference computed elsewhere may change at any time without producing glitches. No handshake or back-pressure exists. A reference driven to or beyond full scale holds its leg at one rail for whole carrier periods, with no switching events. That is how a discontinuous modulation scheme upstream gets its clamped intervals. A global enable turns every switch off.

Top module: `pwm_gate_gen`

## Requirements
- R1: The carrier counter runs 0, 1, …, P, P−1, …, 1 and repeats, so one carrier period lasts 2P clock cycles. P is `period_i`, sampled when the counter is at 0; a value of 0 is used as 1.
- R2: A leg's switching command is high while its sampled reference is greater than the signed carrier value 2·c − P. Over one carrier period, the upper gate is on for max(N − D, 0) cycles and the lower gate for max(2P − N − D, 0) cycles. N is the number of high-command cycles and D is `dead_i`.
- R3: A reference is sampled only at the clock edge that ends a cycle in which the counter sits at 0 or at P. Any value the input takes at other edges has no effect on the gates.
- R4: A sampled reference ≥ P keeps the command high for the whole period. A sampled reference ≤ −P keeps it low. Such a leg shows no gate edges and no dead-time gap.
- R5: On a command change, the gate being turned off goes low at the first clock edge and the other gate goes high D edges later. Both gates of the leg are low for exactly D cycles. With D = 0 the two gates swap at the same edge.
- R6: `gate_o` bit k−1 drives switch k. Phase A uses bits 0 (upper) and 3 (lower). Phase B uses bits 2 and 5. Phase C uses bits 1 and 4.
- R7: The upper and lower gate of one leg are never high in the same cycle.
- R8: While `en` is low, all six gates are low from the next clock edge. After `en` rises, no gate turns on before D clock edges have passed, and the first turn-on happens at the edge D edges after the first enabled edge.
- R9: During reset all six gates are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Gate enable; low forces all gates off |
| ref_a | input | REF_W | Signed reference, phase A |
| ref_b | input | REF_W | Signed reference, phase B |
| ref_c | input | REF_W | Signed reference, phase C |
| period_i | input | CNT_W | Carrier half period P in clock cycles |
| dead_i | input | DT_W | Dead time D in clock cycles |
| gate_o | output | 6 | Gate drives, bit k−1 for switch k |

## Verification
The hardest behaviour to reach from the ports is the rule that references are ignored between the carrier extremes. Nothing on the outputs marks where the extremes fall.

The bench counts clock edges from the release of reset, so it knows which edges close a valley or peak cycle. During a disturbance window it drives the true reference only on those edges and a far-off value on every other edge. The upper gate's on-time must then match the value computed for the undisturbed reference.

The enable check uses clamped references, so the command stays constant and the dead-time count after enable is measured without being restarted.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NUM_LEGS = 3;

  // Switch number (1..6) of the upper device of a phase.
  function automatic int upper_sw(input int leg);
    case (leg)
      0:       return 1;
      1:       return 3;
      default: return 2;
    endcase
  endfunction

  // The lower device of a leg is numbered three above its upper device.
  function automatic int lower_sw(input int leg);
    return upper_sw(leg) + 3;
  endfunction
endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             extreme_o
);
  logic [CNT_W-1:0] cnt_q, per_q, per_in;
  logic             up_q, at_valley, at_peak;

  assign per_in    = (per_i == '0) ? CNT_W'(1) : per_i;
  assign at_valley = (cnt_q == '0);
  assign at_peak   = up_q && !at_valley && (cnt_q >= per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      up_q  <= 1'b1;
    end else if (at_valley) begin
      cnt_q <= CNT_W'(1);
      up_q  <= 1'b1;
      per_q <= per_in;
    end else if (at_peak) begin
      cnt_q <= cnt_q - CNT_W'(1);
      up_q  <= 1'b0;
    end else if (up_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign per_o     = per_q;
  assign extreme_o = at_valley || at_peak;

  // R1: the counter never leaves [0, P]
  a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
  // R1: each cycle the counter moves by exactly one step
  a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/pwm_leg_cmp.sv
module pwm_leg_cmp #(
  parameter int CNT_W = 12,
  parameter int REF_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [REF_W-1:0] ref_i,
  input  logic                    latch_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        per_i,
  output logic                    cmd_o
);
  localparam int CMP_W = ((REF_W > CNT_W + 2) ? REF_W : CNT_W + 2) + 1;

  logic signed [REF_W-1:0] ref_q;
  logic signed [CMP_W-1:0] ref_x, cnt_x, per_x, car_x;
  logic                    full_hi, full_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ref_q <= '0;
    else if (latch_i) ref_q <= ref_i;
  end

  assign ref_x   = CMP_W'(ref_q);
  assign cnt_x   = CMP_W'($signed({1'b0, cnt_i}));
  assign per_x   = CMP_W'($signed({1'b0, per_i}));
  assign car_x   = (cnt_x <<< 1) - per_x;
  assign full_hi = (ref_x >= per_x);
  assign full_lo = (ref_x <= -per_x);

  always_comb begin
    if (per_i == '0)  cmd_o = 1'b0;
    else if (full_hi) cmd_o = 1'b1;
    else if (full_lo) cmd_o = 1'b0;
    else              cmd_o = (ref_x > car_x);
  end

  // R3: the sampled reference only moves at a carrier extreme
  a_r3_hold_between_extremes: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(ref_q));
endmodule

// File: rtl/pwm_dead_band.sv
module pwm_dead_band #(
  parameter int DT_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            cmd_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            cmd_q, en_q, hi_q, lo_q, restart;
  logic [DT_W-1:0] tmr_q, tmr_n;

  // A new command, or a fresh enable, restarts the blanking count.
  assign restart = (cmd_i != cmd_q) || !en_q;

  always_comb begin
    if (!en_i || restart) tmr_n = dead_i;
    else if (tmr_q != '0) tmr_n = tmr_q - DT_W'(1);
    else                  tmr_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 1'b0;
      en_q  <= 1'b0;
      tmr_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      cmd_q <= cmd_i;
      en_q  <= en_i;
      tmr_q <= tmr_n;
      hi_q  <= en_i && cmd_i && (tmr_n == '0);
      lo_q  <= en_i && !cmd_i && (tmr_n == '0);
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R7: no shoot-through on the leg
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));
  // R5: with a non-zero dead time the upper gate rises only after the lower one was off
  a_r5_gap_before_upper: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_q) && dead_i != '0) |-> !$past(lo_q));
  // R5: the same gap on the opposite transition
  a_r5_gap_before_lower: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lo_q) && dead_i != '0) |-> !$past(hi_q));
  // R8: disabling turns the leg off at the next edge
  a_r8_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!hi_q && !lo_q));
endmodule

// File: rtl/pwm_gate_gen.sv
module pwm_gate_gen #(
  parameter int CNT_W = 12,
  parameter int REF_W = 14,
  parameter int DT_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_a,
  input  logic signed [REF_W-1:0] ref_b,
  input  logic signed [REF_W-1:0] ref_c,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [5:0]              gate_o
);
  import pwm_pkg::*;

  logic [CNT_W-1:0]        cnt, per;
  logic                    extreme;
  logic signed [REF_W-1:0] refs [NUM_LEGS];

  assign refs[0] = ref_a;
  assign refs[1] = ref_b;
  assign refs[2] = ref_c;

  pwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_i     (period_i),
    .cnt_o     (cnt),
    .per_o     (per),
    .extreme_o (extreme)
  );

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    localparam int UB = upper_sw(l) - 1;
    localparam int LB = lower_sw(l) - 1;
    logic cmd, hi, lo;

    pwm_leg_cmp #(.CNT_W(CNT_W), .REF_W(REF_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_i   (refs[l]),
      .latch_i (extreme),
      .cnt_i   (cnt),
      .per_i   (per),
      .cmd_o   (cmd)
    );

    pwm_dead_band #(.DT_W(DT_W)) u_db (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .cmd_i  (cmd),
      .dead_i (dead_i),
      .hi_o   (hi),
      .lo_o   (lo)
    );

    assign gate_o[UB] = hi;
    assign gate_o[LB] = lo;
  end
endmodule

// File: tb/pwm_gate_gen_test.sv
module pwm_gate_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int REF_W = 14;
  localparam int DT_W  = 9;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    en = 1'b0;
  logic signed [REF_W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [CNT_W-1:0]        period_i = '0;
  logic [DT_W-1:0]         dead_i = '0;
  logic [5:0]              gate_o;

  pwm_gate_gen #(.CNT_W(CNT_W), .REF_W(REF_W), .DT_W(DT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .period_i(period_i), .dead_i(dead_i), .gate_o(gate_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, edge_n = 0;
  int cur_p = 1, cur_d = 0;
  bit finished = 1'b0;
  int m_hi[3], m_lo[3], m_ovl[3], m_tog[3], m_off[3];
  int dist_val = 2;

  // Bit positions per R6.
  function automatic int ub(input int l);
    return (l == 0) ? 0 : (l == 1) ? 2 : 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    edge_n++;
    @(negedge clk);
  endtask

  // High-command cycles per carrier period, from R2/R4.
  function automatic int n_high(input int r, input int p);
    int n = 0;
    if (r >= p) return 2 * p;
    if (r <= -p) return 0;
    for (int k = 0; k < 2 * p; k++) begin
      int c = (k <= p) ? k : 2 * p - k;
      if (r > 2 * c - p) n++;
    end
    return n;
  endfunction

  function automatic int on_time(input int n, input int p, input int d);
    if (n >= 2 * p) return 2 * p;
    if (n <= 0) return 0;
    return (n > d) ? n - d : 0;
  endfunction

  task automatic set_refs(input int ra, input int rb, input int rc);
    ref_a = REF_W'(ra);
    ref_b = REF_W'(rb);
    ref_c = REF_W'(rc);
  endtask

  task automatic do_reset(input int p, input int d);
    rst_n    = 1'b0;
    en       = 1'b1;
    period_i = CNT_W'(p);
    dead_i   = DT_W'(d);
    cur_p    = (p == 0) ? 1 : p;
    cur_d    = d;
    step();
    step();
    chk("R9", "gates in reset", int'(gate_o), 0);
    rst_n  = 1'b1;
    edge_n = 0;
  endtask

  // Drives the phase A reference: the true value only on edges that close an extreme cycle (R3).
  task automatic drive_disturb();
    if (((edge_n + 1) % cur_p) == 1 % cur_p) ref_a = REF_W'(dist_val);
    else ref_a = REF_W'(((edge_n & 1) != 0) ? 200 : -200);
  endtask

  task automatic settle(input int n, input bit disturb);
    for (int i = 0; i < n; i++) begin
      if (disturb) drive_disturb();
      step();
    end
  endtask

  task automatic measure(input bit disturb);
    logic [5:0] prev;
    for (int l = 0; l < 3; l++) begin
      m_hi[l] = 0; m_lo[l] = 0; m_ovl[l] = 0; m_tog[l] = 0; m_off[l] = 0;
    end
    prev = gate_o;
    for (int i = 0; i < 2 * cur_p; i++) begin
      if (disturb) drive_disturb();
      step();
      for (int l = 0; l < 3; l++) begin
        logic h, o;
        h = gate_o[ub(l)];
        o = gate_o[ub(l) + 3];
        if (h) m_hi[l]++;
        if (o) m_lo[l]++;
        if (h && o) m_ovl[l]++;
        if (!h && !o) m_off[l]++;
        if (h != prev[ub(l)]) m_tog[l]++;
        if (o != prev[ub(l) + 3]) m_tog[l]++;
      end
      prev = gate_o;
    end
  endtask

  // Cycles between two successive rising edges of the phase A upper gate.
  task automatic rise_gap(output int gap);
    logic p;
    int t = 0;
    gap = -1;
    p = gate_o[0];
    for (int i = 0; i < 8 * cur_p + 8; i++) begin
      step();
      if (gate_o[0] && !p) break;
      p = gate_o[0];
    end
    p = gate_o[0];
    for (int i = 0; i < 8 * cur_p + 8; i++) begin
      step();
      t++;
      if (gate_o[0] && !p) begin
        gap = t;
        break;
      end
      p = gate_o[0];
    end
  endtask

  initial begin
    int dvals[3];
    int gap, zeros;
    dvals[0] = 0; dvals[1] = 1; dvals[2] = 3;

    // Sweep of references and dead times over a small carrier: R2, R4, R5, R7
    foreach (dvals[di]) begin
      do_reset(6, dvals[di]);
      for (int r = -8; r <= 8; r++) begin
        int rv[3];
        rv[0] = r; rv[1] = -r; rv[2] = r / 2;
        set_refs(rv[0], rv[1], rv[2]);
        settle(4 * cur_p, 1'b0);
        measure(1'b0);
        for (int l = 0; l < 3; l++) begin
          int n, eh, el;
          bit clamped;
          n = n_high(rv[l], cur_p);
          clamped = (rv[l] >= cur_p) || (rv[l] <= -cur_p);
          eh = on_time(n, cur_p, cur_d);
          el = on_time(2 * cur_p - n, cur_p, cur_d);
          chk(clamped ? "R4" : "R2", "upper on-time", m_hi[l], eh);
          chk(clamped ? "R4" : "R2", "lower on-time", m_lo[l], el);
          chk("R7", "overlap cycles", m_ovl[l], 0);
          if (clamped) chk("R4", "edges on clamped leg", m_tog[l], 0);
          else if (n > cur_d && 2 * cur_p - n > cur_d)
            chk("R5", "both-off cycles", m_off[l], 2 * cur_d);
        end
      end
    end

    // Carrier period: R1
    do_reset(9, 1);
    set_refs(0, 0, 0);
    settle(4 * cur_p, 1'b0);
    rise_gap(gap);
    chk("R1", "period for P=9", gap, 18);
    do_reset(0, 0);
    set_refs(0, 0, 0);
    settle(8, 1'b0);
    rise_gap(gap);
    chk("R1", "period for P=0 (used as 1)", gap, 2);

    // Reference ignored between extremes: R3
    do_reset(6, 1);
    set_refs(2, 0, 0);
    dist_val = 2;
    settle(4 * cur_p, 1'b1);
    measure(1'b1);
    chk("R3", "upper on-time under disturbance", m_hi[0], on_time(n_high(2, 6), 6, 1));
    chk("R3", "lower on-time under disturbance", m_lo[0], on_time(12 - n_high(2, 6), 6, 1));
    dist_val = -3;
    settle(4 * cur_p, 1'b1);
    measure(1'b1);
    chk("R3", "upper on-time, second value", m_hi[0], on_time(n_high(-3, 6), 6, 1));

    // Leg-to-switch map: R6
    do_reset(6, 0);
    set_refs(100, -100, 100);
    settle(4 * cur_p, 1'b0);
    chk("R6", "gate vector A high, B low, C high", int'(gate_o), 'h23);
    set_refs(-100, 100, -100);
    settle(4 * cur_p, 1'b0);
    chk("R6", "gate vector A low, B high, C low", int'(gate_o), 'h1c);

    // Enable behaviour: R8
    do_reset(6, 3);
    set_refs(100, -100, 100);
    settle(4 * cur_p, 1'b0);
    en = 1'b0;
    step();
    chk("R8", "gates one edge after disable", int'(gate_o), 0);
    settle(5, 1'b0);
    chk("R8", "gates while disabled", int'(gate_o), 0);
    en = 1'b1;
    zeros = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (gate_o != 6'd0) break;
      zeros++;
    end
    chk("R8", "off edges after enable", zeros, 3);
    chk("R8", "first gate vector after enable", int'(gate_o), 'h23);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule